// File: doc/BRIEF.md
# Timer Event Interrupt Collector

This block gathers one-cycle event pulses from up to 32 timer channels into sticky flag bits. It reports pending channels on three level-type interrupt lines. Each channel has a mask bit. A channel is pending while its flag is set and its mask bit is clear. Software works through a small register port with separate write and read strobes, an address and 32-bit data. It reads the flags and the mask directly. Flags are cleared by writing ones to a clear strobe register. Mask bits are changed only through a set strobe and a clear strobe, so a change to one channel never disturbs another.

A build-time parameter picks how channels 0 to 7 map onto the lines. In layout A, channel 0 and channel 1 each have a line of their own, and channels 2 to 7 share the third line. In layout B, channel 5 has a line of its own and every other channel from 0 to 7 shares a second line. Channels 8 and above keep flags and masks but feed no line. To enable a channel, software clears its flag first and then clears its mask bit, so a stale event does not raise the line.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: After reset, every flag is 0, every mask bit is 1 and all three lines are low.
- R2: A pulse on source bit i sets flag i at the next clock edge, whether or not channel i is masked. The flag holds until it is cleared.
- R3: A write to address 1 (flag clear) clears each flag whose data bit is 1. Bits written as 0 leave their flags unchanged.
- R4: A write to address 3 (mask set) sets each mask bit whose data bit is 1. A write to address 4 (mask clear) clears each mask bit whose data bit is 1. Bits written as 0 leave the mask unchanged.
- R5: Channel i is pending when flag i is 1 and mask i is 0. A line is high for as long as at least one pending channel belongs to its group.
- R6: With GROUP_MODE=0 (layout A), irq_line[0] serves channel 0 and irq_line[1] serves channel 1. irq_line[2] serves channels 2 to 7.
- R7: With GROUP_MODE=1 (layout B), irq_line[0] serves channel 5 and irq_line[1] serves channels 0 to 4, 6 and 7. irq_line[2] stays low.
- R8: When a source pulse and a flag-clear write hit the same bit in the same cycle, the flag ends up set.
- R9: While rd_en is high, rd_data shows the flags at address 0 and the mask at address 2. It shows 0 at every other address, including the strobe addresses 1, 3 and 4. While rd_en is low, rd_data is 0.
- R10: Channels 8 to 31 keep their flags and masks, but a pending channel there raises no line.
- R11: Clearing a channel's stale flag and then clearing its mask bit leaves the line low. A later event on that channel raises the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_evt | input | NUM_CH | One-cycle event pulses, one bit per channel |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Register address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational |
| irq_line | output | 3 | Level interrupt lines |

## Verification
The assertions assume that wr_en and rd_en are never high in the same cycle. They also assume that a write hits one register per cycle. The stimulus drives at most one strobe at a time, always on a falling edge, and raises source pulses for exactly one cycle. The only overlap it creates on purpose is a source pulse in the same cycle as a flag-clear write, which exercises the rule that the event wins. Two instances, one per layout, share the same inputs, so each event pattern checks both groupings at once.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int REG_ADDR_W = 3;
  localparam int DATA_W     = 32;
  localparam int LINES      = 3;
  localparam int GROUPED_CH = 8;

  typedef enum logic [REG_ADDR_W-1:0] {
    RA_FLAG  = 3'd0,
    RA_FCLR  = 3'd1,
    RA_MASK  = 3'd2,
    RA_MSET  = 3'd3,
    RA_MCLR  = 3'd4
  } reg_addr_e;

  // Update helpers, kept as functions so the bench can restate them its own way
  function automatic logic [DATA_W-1:0] flag_update(
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] clr,
    input logic [DATA_W-1:0] evt);
    return (cur & ~clr) | evt;
  endfunction

  function automatic logic [DATA_W-1:0] mask_update(
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] setv,
    input logic [DATA_W-1:0] clrv);
    return (cur | setv) & ~clrv;
  endfunction
endpackage

// File: rtl/tmr_irq_regif.sv
module tmr_irq_regif
  import tmr_irq_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int ADDR_W = REG_ADDR_W
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  input  logic [NUM_CH-1:0] flag_q,
  input  logic [NUM_CH-1:0] mask_q,
  output logic [NUM_CH-1:0] fclr_vec,
  output logic [NUM_CH-1:0] mset_vec,
  output logic [NUM_CH-1:0] mclr_vec,
  output logic [31:0]       rd_data
);
  logic hit_fclr, hit_mset, hit_mclr;

  always_comb begin
    hit_fclr = wr_en && (addr == ADDR_W'(RA_FCLR));
    hit_mset = wr_en && (addr == ADDR_W'(RA_MSET));
    hit_mclr = wr_en && (addr == ADDR_W'(RA_MCLR));
    fclr_vec = hit_fclr ? wr_data[NUM_CH-1:0] : '0;
    mset_vec = hit_mset ? wr_data[NUM_CH-1:0] : '0;
    mclr_vec = hit_mclr ? wr_data[NUM_CH-1:0] : '0;
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (addr == ADDR_W'(RA_FLAG)) rd_data[NUM_CH-1:0] = flag_q;
      else if (addr == ADDR_W'(RA_MASK)) rd_data[NUM_CH-1:0] = mask_q;
    end
  end
endmodule

// File: rtl/tmr_irq_state.sv
module tmr_irq_state
  import tmr_irq_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] src_evt,
  input  logic [NUM_CH-1:0] fclr_vec,
  input  logic [NUM_CH-1:0] mset_vec,
  input  logic [NUM_CH-1:0] mclr_vec,
  output logic [NUM_CH-1:0] flag_q,
  output logic [NUM_CH-1:0] mask_q
);
  logic [DATA_W-1:0] flag_nx, mask_nx;

  always_comb begin
    flag_nx = flag_update(DATA_W'(flag_q), DATA_W'(fclr_vec), DATA_W'(src_evt));
    mask_nx = mask_update(DATA_W'(mask_q), DATA_W'(mset_vec), DATA_W'(mclr_vec));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '1;
    end else begin
      flag_q <= flag_nx[NUM_CH-1:0];
      mask_q <= mask_nx[NUM_CH-1:0];
    end
  end
endmodule

// File: rtl/tmr_irq_group.sv
module tmr_irq_group
  import tmr_irq_pkg::*;
#(
  parameter int NUM_CH     = 32,
  parameter int GROUP_MODE = 0
) (
  input  logic [NUM_CH-1:0] pend,
  output logic [LINES-1:0]  irq_line
);
  // Membership of channel ch in line ln for the selected layout
  function automatic logic member(input int ln, input int ch);
    if (ch >= GROUPED_CH) return 1'b0;
    if (GROUP_MODE == 0) begin
      case (ln)
        0: return ch == 0;
        1: return ch == 1;
        default: return ch >= 2;
      endcase
    end else begin
      case (ln)
        0: return ch == 5;
        1: return ch != 5;
        default: return 1'b0;
      endcase
    end
  endfunction

  for (genvar ln = 0; ln < LINES; ln++) begin : g_line
    logic [NUM_CH-1:0] sel;
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      assign sel[ch] = member(ln, ch);
    end
    assign irq_line[ln] = |(pend & sel);
  end
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tmr_irq_pkg::*;
#(
  parameter int NUM_CH     = 32,
  parameter int ADDR_W     = REG_ADDR_W,
  parameter int GROUP_MODE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] src_evt,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic [2:0]        irq_line
);
  logic [NUM_CH-1:0] flag_q, mask_q;
  logic [NUM_CH-1:0] fclr_vec, mset_vec, mclr_vec;
  logic [NUM_CH-1:0] pend;

  tmr_irq_regif #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regif (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
    .flag_q(flag_q), .mask_q(mask_q),
    .fclr_vec(fclr_vec), .mset_vec(mset_vec), .mclr_vec(mclr_vec),
    .rd_data(rd_data)
  );

  tmr_irq_state #(.NUM_CH(NUM_CH)) u_state (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt),
    .fclr_vec(fclr_vec), .mset_vec(mset_vec), .mclr_vec(mclr_vec),
    .flag_q(flag_q), .mask_q(mask_q)
  );

  assign pend = flag_q & ~mask_q;

  tmr_irq_group #(.NUM_CH(NUM_CH), .GROUP_MODE(GROUP_MODE)) u_group (
    .pend(pend), .irq_line(irq_line)
  );
endmodule

// File: rtl/tmr_irq_chk.sv
module tmr_irq_chk #(
  parameter int NUM_CH = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] src_evt,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wr_data,
  input logic [31:0]       rd_data,
  input logic [2:0]        irq_line,
  input logic [NUM_CH-1:0] flag_q,
  input logic [NUM_CH-1:0] mask_q
);
  // R2 / R8: any event bit is visible as a flag one edge later
  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_evt) |=> ((flag_q & $past(src_evt)) == $past(src_evt)));

  // R3: written ones without a simultaneous event leave the flag clear
  a_r3_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(1)) |=>
      ((flag_q & $past(wr_data[NUM_CH-1:0]) & ~$past(src_evt)) == '0));

  // R4: mask set strobe
  a_r4_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(3)) |=>
      ((mask_q & $past(wr_data[NUM_CH-1:0])) == $past(wr_data[NUM_CH-1:0])));

  // R4: mask clear strobe
  a_r4_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(4)) |=>
      ((mask_q & $past(wr_data[NUM_CH-1:0])) == '0));

  // R4: mask only moves on its strobes
  a_r4_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == ADDR_W'(3) || addr == ADDR_W'(4))) |=> $stable(mask_q));

  // R5 / R10: no pending channel among 0..7 means all lines low
  a_r5_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q[7:0] & ~mask_q[7:0]) == 8'h00) |-> (irq_line == 3'b000));

  // R9: strobe addresses read back as zero
  a_r9_strobe_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == ADDR_W'(1) || addr == ADDR_W'(3) || addr == ADDR_W'(4)))
      |-> (rd_data == 32'h0));

  // R9: idle read port drives zero
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == 32'h0));
endmodule

bind tmr_irq_ctrl tmr_irq_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_line(irq_line),
  .flag_q(flag_q), .mask_q(mask_q)
);

// File: tb/tmr_irq_ctrl_test.sv
module tmr_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_evt = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_a, rd_b;
  logic [2:0]  line_a, line_b;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  tmr_irq_ctrl #(.GROUP_MODE(0)) uut (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_a), .irq_line(line_a));

  tmr_irq_ctrl #(.GROUP_MODE(1)) uut_b (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_b), .irq_line(line_b));

  // Behavioural reference, bit by bit
  bit [31:0] m_flag;
  bit [31:0] m_mask;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flag = 32'h0;
      m_mask = 32'hFFFF_FFFF;
    end else begin
      for (int i = 0; i < 32; i++) begin
        if (src_evt[i]) m_flag[i] = 1'b1;
        else if (wr_en && addr == 3'd1 && wr_data[i]) m_flag[i] = 1'b0;
        if (wr_en && addr == 3'd3 && wr_data[i]) m_mask[i] = 1'b1;
        if (wr_en && addr == 3'd4 && wr_data[i]) m_mask[i] = 1'b0;
      end
    end
  end

  function automatic bit [2:0] ref_lines(input bit layout_b);
    bit [2:0] r = 3'b000;
    for (int t = 0; t < 8; t++) begin
      if (m_flag[t] && !m_mask[t]) begin
        if (!layout_b) begin
          if (t == 0) r[0] = 1'b1;
          else if (t == 1) r[1] = 1'b1;
          else r[2] = 1'b1;
        end else begin
          if (t == 5) r[0] = 1'b1;
          else r[1] = 1'b1;
        end
      end
    end
    return r;
  endfunction

  function automatic bit [31:0] ref_read();
    if (!rd_en) return 32'h0;
    if (addr == 3'd0) return m_flag;
    if (addr == 3'd2) return m_mask;
    return 32'h0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(line_a == ref_lines(1'b0), "R6 layout A lines vs model", {29'h0, line_a}, {29'h0, ref_lines(1'b0)});
      check(line_b == ref_lines(1'b1), "R7 layout B lines vs model", {29'h0, line_b}, {29'h0, ref_lines(1'b1)});
      check(rd_a == ref_read(), "R9 read data vs model", rd_a, ref_read());
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 100000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); #1;
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(input logic [31:0] v);
    @(negedge clk); #1;
    src_evt = v;
    @(negedge clk); #1;
    src_evt = '0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); #1;
    rd_en = 1'b1; addr = a;
    #1;
    check(rd_a === exp, tag, rd_a, exp);
    @(negedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic line_chk(input logic [2:0] ea, input logic [2:0] eb, input string tag);
    check(line_a === ea, {tag, " layout A"}, {29'h0, line_a}, {29'h0, ea});
    check(line_b === eb, {tag, " layout B"}, {29'h0, line_b}, {29'h0, eb});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    line_chk(3'b000, 3'b000, "R1 lines after reset");
    rd_chk(3'd0, 32'h0, "R1 flags after reset");
    rd_chk(3'd2, 32'hFFFF_FFFF, "R1 mask after reset");

    pulse(32'h7);
    rd_chk(3'd0, 32'h7, "R2 flags set while masked");
    line_chk(3'b000, 3'b000, "R2 masked lines stay low");

    wr(3'd1, 32'h0);
    rd_chk(3'd0, 32'h7, "R3 zero clear has no effect");
    wr(3'd1, 32'h2);
    rd_chk(3'd0, 32'h5, "R3 clear one flag");

    wr(3'd4, 32'h1);
    rd_chk(3'd2, 32'hFFFF_FFFE, "R4 mask clear strobe");
    line_chk(3'b001, 3'b010, "R6 R7 channel 0 routing");
    wr(3'd3, 32'h0);
    rd_chk(3'd2, 32'hFFFF_FFFE, "R4 zero mask set has no effect");

    wr(3'd4, 32'hC);
    line_chk(3'b101, 3'b010, "R5 channels 0 and 2 pending");
    pulse(32'h8);
    wr(3'd1, 32'h5);
    line_chk(3'b100, 3'b010, "R5 line held by channel 3");
    wr(3'd1, 32'h8);
    line_chk(3'b000, 3'b000, "R5 line drops after last flag");

    wr(3'd3, 32'hD);
    rd_chk(3'd2, 32'hFFFF_FFFF, "R4 mask set strobe");
    wr(3'd4, 32'h20);
    pulse(32'h20);
    line_chk(3'b100, 3'b001, "R6 R7 channel 5 routing");
    wr(3'd1, 32'h20);
    line_chk(3'b000, 3'b000, "R3 channel 5 cleared");

    wr(3'd4, 32'h0010_0000);
    pulse(32'h0010_0000);
    rd_chk(3'd0, 32'h0010_0000, "R10 high channel keeps flag");
    rd_chk(3'd2, 32'hFFEF_FFDF, "R10 high channel keeps mask");
    line_chk(3'b000, 3'b000, "R10 high channel drives no line");
    wr(3'd1, 32'h0010_0000);

    wr(3'd4, 32'h2);
    @(negedge clk); #1;
    src_evt = 32'h2; wr_en = 1'b1; addr = 3'd1; wr_data = 32'h2;
    @(negedge clk); #1;
    src_evt = '0; wr_en = 1'b0; wr_data = '0;
    rd_chk(3'd0, 32'h2, "R8 event beats clear");
    line_chk(3'b010, 3'b010, "R8 channel 1 line");
    wr(3'd1, 32'h2);

    pulse(32'h40);
    line_chk(3'b000, 3'b000, "R11 stale flag masked");
    wr(3'd1, 32'h40);
    wr(3'd4, 32'h40);
    line_chk(3'b000, 3'b000, "R11 no spurious line after unmask");
    pulse(32'h40);
    line_chk(3'b100, 3'b010, "R11 fresh event raises line");

    rd_chk(3'd1, 32'h0, "R9 flag clear reads zero");
    rd_chk(3'd3, 32'h0, "R9 mask set reads zero");
    rd_chk(3'd4, 32'h0, "R9 mask clear reads zero");
    rd_chk(3'd7, 32'h0, "R9 unused address reads zero");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule